// File: doc/BRIEF.md
# Synchronous Serial Port Control Core

This block is the control heart of a synchronous serial port. Software programs a small control register through a simple write/read port. The register masks the two FIFO interrupts, selects an internal transmit-to-receive loop, and sets the serial clock's idle polarity and sampling phase for the SPI frame format. Two further registers hold the FIFO level thresholds. The block compares the transmit and receive FIFO levels against these thresholds every cycle and produces service-request status bits. It drives unmasked DMA requests from those bits and interrupt lines that the enables can mask.

On the serial side, the block sits between the transmit and receive shifters and the port pins. When looping is off, the two data directions use their own pins. When looping is on, the transmit shifter output feeds the receive shifter input, the pin drivers are parked low, and a handoff flag tells an external pin-control unit that it owns the pins. The serial clock from the shifter logic is idle-low by convention. This block inverts it when SPI format with high polarity is selected, and it tells the shifters which clock edge to sample on. Fields that affect the pins are applied only while no transfer is running.

Top module: `serport_core`

## Requirements
- R1: On reset, every control field is 0, both service-request bits are 0, both interrupts and both DMA requests are low, the handoff flag is low and the clock pin is low. Both thresholds reset to FIFO_DEPTH/2.
- R2: The receive service bit is registered. It is 1 in the cycle after the receive level is at or above the receive threshold, and 0 otherwise. It reads back at status bit 0.
- R3: The transmit service bit is registered. It is 1 in the cycle after the transmit level is at or below the transmit threshold, and 0 otherwise. It reads back at status bit 1.
- R4: rxIrq equals the receive service bit AND control bit 1. txIrq equals the transmit service bit AND control bit 2. Clearing an enable leaves the service bit unchanged, and the level comparison continues to set and clear that bit.
- R5: rxDmaReq and txDmaReq equal the receive and transmit service bits, whatever the interrupt enables are.
- R6: With control bit 0 (loop) set, rxShiftIn equals txShiftOut, txPin, sclkPin and frmPin are held low, and pinHandoff is 1. With bit 0 clear, rxShiftIn equals rxPin, txPin equals txShiftOut, frmPin equals frmRaw and pinHandoff is 0.
- R7: In SPI format (control bits 6:5 = 00) with loop off, sclkPin equals sclkRaw XOR control bit 3 (polarity), so the idle clock level equals the polarity bit.
- R8: In any format other than 00, polarity is ignored: sclkPin equals sclkRaw and sampleOnRise is 1.
- R9: In SPI format, sampleOnRise is 1 exactly when polarity (bit 3) equals phase (bit 4). Data is driven on the opposite edge.
- R10: While xferActive is high, writes to control bits 0, 3, 4, 6:5 take no effect on the pins. They are applied within two cycles once xferActive is low. Readback shows the written value at once, and the interrupt enables act from the cycle after the write.
- R11: The register map is: address 0 holds the control register (bits 6:0), address 1 the receive threshold, address 2 the transmit threshold, and address 3 the read-only status. Writes take effect at the clock edge where wrEn is high, and reads are combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wrEn | input | 1 | Register write strobe |
| addr | input | 2 | Register address |
| wrData | input | 7 | Write data |
| rdData | output | 7 | Read data for addr |
| rxLevel | input | 4 | Receive FIFO fill level |
| txLevel | input | 4 | Transmit FIFO fill level |
| xferActive | input | 1 | A serial transfer is in progress |
| txShiftOut | input | 1 | Serial output of the transmit shifter |
| rxPin | input | 1 | Receive data pin |
| sclkRaw | input | 1 | Shifter serial clock, idle low |
| frmRaw | input | 1 | Shifter frame signal |
| rxShiftIn | output | 1 | Serial input to the receive shifter |
| txPin | output | 1 | Transmit data pin |
| sclkPin | output | 1 | Serial clock pin |
| frmPin | output | 1 | Frame pin |
| pinHandoff | output | 1 | Pins belong to the external pin-control unit |
| sampleOnRise | output | 1 | Shifters sample on the rising clock edge |
| rxIrq | output | 1 | Receive interrupt request |
| txIrq | output | 1 | Transmit interrupt request |
| rxDmaReq | output | 1 | Receive DMA request |
| txDmaReq | output | 1 | Transmit DMA request |

## Verification
The clock properties assume that sclkRaw is low whenever no transfer is running, so the pin's idle level shows the polarity bit. The hold property assumes that xferActive covers each whole transfer. The bench keeps sclkRaw low during every transfer it marks as active and toggles it only in the vector checks, where xferActive is low. Levels are always driven within 0 to FIFO_DEPTH, and register writes are one cycle long and spaced apart, so every service bit can be traced to the level and threshold of the previous cycle.

// File: rtl/serport_pkg.sv
package serport_pkg;
  // Control register, bit 0 at the bottom of the list
  typedef struct packed {
    logic [1:0] frameFmt;  // bits 6:5, 00 selects SPI
    logic       clkPha;    // bit 4
    logic       clkPol;    // bit 3
    logic       txIntEn;   // bit 2
    logic       rxIntEn;   // bit 1
    logic       loopEn;    // bit 0
  } ctrlReg_t;

  localparam int CTRL_W = $bits(ctrlReg_t);
  localparam logic [1:0] FMT_SPI = 2'b00;

  localparam logic [1:0] ADDR_CTRL   = 2'd0;
  localparam logic [1:0] ADDR_RXTH   = 2'd1;
  localparam logic [1:0] ADDR_TXTH   = 2'd2;
  localparam logic [1:0] ADDR_STATUS = 2'd3;

  // Strobes from control to datapath
  typedef struct packed {
    logic wrCtrl;
    logic wrRxTh;
    logic wrTxTh;
    logic applyCfg;
  } strobe_t;
endpackage

// File: rtl/serport_ctrl.sv
module serport_ctrl
  import serport_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wrEn,
  input  logic [1:0] addr,
  input  logic       xferActive,
  output strobe_t    strb
);
  logic pendingQ;

  always_comb begin
    strb.wrCtrl   = wrEn && (addr == ADDR_CTRL);
    strb.wrRxTh   = wrEn && (addr == ADDR_RXTH);
    strb.wrTxTh   = wrEn && (addr == ADDR_TXTH);
    strb.applyCfg = pendingQ && !xferActive;
  end

  // A control write stays pending until a cycle with no transfer
  always_ff @(posedge clk) begin
    if (rst)                pendingQ <= 1'b0;
    else if (strb.wrCtrl)   pendingQ <= 1'b1;
    else if (strb.applyCfg) pendingQ <= 1'b0;
  end
endmodule

// File: rtl/serport_datapath.sv
module serport_datapath
  import serport_pkg::*;
#(
  parameter int LVL_W  = 4,
  parameter int DATA_W = 7,
  parameter int TH_RST = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  strobe_t           strb,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic [LVL_W-1:0]  rxLevel,
  input  logic [LVL_W-1:0]  txLevel,
  input  logic              txShiftOut,
  input  logic              rxPin,
  input  logic              sclkRaw,
  input  logic              frmRaw,
  output logic              rxShiftIn,
  output logic              txPin,
  output logic              sclkPin,
  output logic              frmPin,
  output logic              pinHandoff,
  output logic              sampleOnRise,
  output logic              rxIrq,
  output logic              txIrq,
  output logic              rxDmaReq,
  output logic              txDmaReq,
  output ctrlReg_t          shadowCfg,
  output ctrlReg_t          activeCfg,
  output logic [LVL_W-1:0]  rxThresh,
  output logic [LVL_W-1:0]  txThresh
);
  localparam logic [LVL_W-1:0] TH_INIT = LVL_W'(TH_RST);

  logic rxSvc, txSvc;
  logic isSpi;

  // Register file
  always_ff @(posedge clk) begin
    if (rst) begin
      shadowCfg <= '0;
      activeCfg <= '0;
      rxThresh  <= TH_INIT;
      txThresh  <= TH_INIT;
    end else begin
      if (strb.wrCtrl)   shadowCfg <= ctrlReg_t'(wrData[CTRL_W-1:0]);
      if (strb.applyCfg) activeCfg <= shadowCfg;
      if (strb.wrRxTh)   rxThresh  <= wrData[LVL_W-1:0];
      if (strb.wrTxTh)   txThresh  <= wrData[LVL_W-1:0];
    end
  end

  // Service requests, recomputed every cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      rxSvc <= 1'b0;
      txSvc <= 1'b0;
    end else begin
      rxSvc <= (rxLevel >= rxThresh);
      txSvc <= (txLevel <= txThresh);
    end
  end

  assign rxDmaReq = rxSvc;
  assign txDmaReq = txSvc;
  assign rxIrq    = rxSvc && shadowCfg.rxIntEn;
  assign txIrq    = txSvc && shadowCfg.txIntEn;

  always_comb begin
    case (addr)
      ADDR_CTRL:   rdData = DATA_W'(shadowCfg);
      ADDR_RXTH:   rdData = DATA_W'(rxThresh);
      ADDR_TXTH:   rdData = DATA_W'(txThresh);
      default:     rdData = DATA_W'({txSvc, rxSvc});
    endcase
  end

  // Serial path and pin control
  assign isSpi        = (activeCfg.frameFmt == FMT_SPI);
  assign pinHandoff   = activeCfg.loopEn;
  assign rxShiftIn    = activeCfg.loopEn ? txShiftOut : rxPin;
  assign txPin        = !activeCfg.loopEn && txShiftOut;
  assign frmPin       = !activeCfg.loopEn && frmRaw;
  assign sclkPin      = !activeCfg.loopEn && (sclkRaw ^ (isSpi && activeCfg.clkPol));
  assign sampleOnRise = isSpi ? (activeCfg.clkPol == activeCfg.clkPha) : 1'b1;
endmodule

// File: rtl/serport_core.sv
module serport_core
  import serport_pkg::*;
#(
  parameter int FIFO_DEPTH = 8,
  parameter int LVL_W      = $clog2(FIFO_DEPTH + 1),
  parameter int DATA_W     = (CTRL_W > LVL_W) ? CTRL_W : LVL_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic [LVL_W-1:0]  rxLevel,
  input  logic [LVL_W-1:0]  txLevel,
  input  logic              xferActive,
  input  logic              txShiftOut,
  input  logic              rxPin,
  input  logic              sclkRaw,
  input  logic              frmRaw,
  output logic              rxShiftIn,
  output logic              txPin,
  output logic              sclkPin,
  output logic              frmPin,
  output logic              pinHandoff,
  output logic              sampleOnRise,
  output logic              rxIrq,
  output logic              txIrq,
  output logic              rxDmaReq,
  output logic              txDmaReq
);
  strobe_t          strb;
  ctrlReg_t         shadowCfg, activeCfg;
  logic [LVL_W-1:0] rxThresh, txThresh;

  serport_ctrl i_ctrl (
    .clk(clk), .rst(rst), .wrEn(wrEn), .addr(addr),
    .xferActive(xferActive), .strb(strb)
  );

  serport_datapath #(.LVL_W(LVL_W), .DATA_W(DATA_W), .TH_RST(FIFO_DEPTH / 2)) i_dp (
    .clk(clk), .rst(rst), .strb(strb), .addr(addr), .wrData(wrData),
    .rdData(rdData), .rxLevel(rxLevel), .txLevel(txLevel),
    .txShiftOut(txShiftOut), .rxPin(rxPin), .sclkRaw(sclkRaw), .frmRaw(frmRaw),
    .rxShiftIn(rxShiftIn), .txPin(txPin), .sclkPin(sclkPin), .frmPin(frmPin),
    .pinHandoff(pinHandoff), .sampleOnRise(sampleOnRise),
    .rxIrq(rxIrq), .txIrq(txIrq), .rxDmaReq(rxDmaReq), .txDmaReq(txDmaReq),
    .shadowCfg(shadowCfg), .activeCfg(activeCfg),
    .rxThresh(rxThresh), .txThresh(txThresh)
  );
endmodule

// File: rtl/serport_checker.sv
module serport_checker
  import serport_pkg::*;
#(
  parameter int LVL_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             xferActive,
  input logic [LVL_W-1:0] rxLevel,
  input logic [LVL_W-1:0] txLevel,
  input logic [LVL_W-1:0] rxThresh,
  input logic [LVL_W-1:0] txThresh,
  input logic             rxIntEn,
  input logic             txIntEn,
  input ctrlReg_t         activeCfg,
  input logic             rxIrq,
  input logic             txIrq,
  input logic             rxDmaReq,
  input logic             txDmaReq,
  input logic             txShiftOut,
  input logic             rxShiftIn,
  input logic             txPin,
  input logic             sclkRaw,
  input logic             sclkPin,
  input logic             frmPin,
  input logic             pinHandoff
);
  logic started;
  always_ff @(posedge clk) begin
    if (rst) started <= 1'b0;
    else     started <= 1'b1;
  end

  p_rx_svc_r2: assert property (@(posedge clk) disable iff (rst)
    started |-> (rxDmaReq == $past(rxLevel >= rxThresh)));

  p_tx_svc_r3: assert property (@(posedge clk) disable iff (rst)
    started |-> (txDmaReq == $past(txLevel <= txThresh)));

  p_irq_mask_r4: assert property (@(posedge clk) disable iff (rst)
    (!rxIntEn |-> !rxIrq) and (!txIntEn |-> !txIrq));

  p_irq_implies_dma_r5: assert property (@(posedge clk) disable iff (rst)
    (rxIrq |-> rxDmaReq) and (txIrq |-> txDmaReq));

  p_loop_path_r6: assert property (@(posedge clk) disable iff (rst)
    activeCfg.loopEn |-> (rxShiftIn == txShiftOut) && pinHandoff
                         && !txPin && !sclkPin && !frmPin);

  p_idle_level_r7: assert property (@(posedge clk) disable iff (rst)
    (activeCfg.frameFmt == FMT_SPI && !activeCfg.loopEn && !sclkRaw)
      |-> (sclkPin == activeCfg.clkPol));

  p_pol_ignored_r8: assert property (@(posedge clk) disable iff (rst)
    (activeCfg.frameFmt != FMT_SPI && !activeCfg.loopEn) |-> (sclkPin == sclkRaw));

  p_hold_in_xfer_r10: assert property (@(posedge clk) disable iff (rst)
    xferActive |=> $stable(activeCfg));
endmodule

bind serport_core serport_checker #(.LVL_W(LVL_W)) i_chk (
  .clk(clk), .rst(rst), .xferActive(xferActive),
  .rxLevel(rxLevel), .txLevel(txLevel),
  .rxThresh(rxThresh), .txThresh(txThresh),
  .rxIntEn(shadowCfg.rxIntEn), .txIntEn(shadowCfg.txIntEn),
  .activeCfg(activeCfg),
  .rxIrq(rxIrq), .txIrq(txIrq), .rxDmaReq(rxDmaReq), .txDmaReq(txDmaReq),
  .txShiftOut(txShiftOut), .rxShiftIn(rxShiftIn), .txPin(txPin),
  .sclkRaw(sclkRaw), .sclkPin(sclkPin), .frmPin(frmPin), .pinHandoff(pinHandoff)
);

// File: tb/test_serport_core.sv
module test_serport_core;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wrEn = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [6:0] wrData = '0;
  logic [6:0] rdData;
  logic [3:0] rxLevel = '0, txLevel = '0;
  logic       xferActive = 1'b0, txShiftOut = 1'b0, rxPin = 1'b0;
  logic       sclkRaw = 1'b0, frmRaw = 1'b0;
  logic       rxShiftIn, txPin, sclkPin, frmPin, pinHandoff, sampleOnRise;
  logic       rxIrq, txIrq, rxDmaReq, txDmaReq;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #5 clk = ~clk;

  serport_core i_serport_core (
    .clk(clk), .rst(rst), .wrEn(wrEn), .addr(addr), .wrData(wrData), .rdData(rdData),
    .rxLevel(rxLevel), .txLevel(txLevel), .xferActive(xferActive),
    .txShiftOut(txShiftOut), .rxPin(rxPin), .sclkRaw(sclkRaw), .frmRaw(frmRaw),
    .rxShiftIn(rxShiftIn), .txPin(txPin), .sclkPin(sclkPin), .frmPin(frmPin),
    .pinHandoff(pinHandoff), .sampleOnRise(sampleOnRise),
    .rxIrq(rxIrq), .txIrq(txIrq), .rxDmaReq(rxDmaReq), .txDmaReq(txDmaReq)
  );

  // {ctrl7, rxTh4, txTh4, rxLvl4, txLvl4, {txShiftOut,rxPin,sclkRaw},
  //  {rxIrq,txIrq}, {rxDma,txDma}, {rxShiftIn,txPin,sclkPin,sampleOnRise,pinHandoff}}
  localparam int NV = 12;
  localparam logic [34:0] VECS [NV] = '{
    {7'd0,  4'd4, 4'd2, 4'd5, 4'd1, 3'b100, 2'b00, 2'b11, 5'b01010},
    {7'd6,  4'd4, 4'd2, 4'd3, 4'd3, 3'b011, 2'b00, 2'b00, 5'b10110},
    {7'd6,  4'd4, 4'd2, 4'd4, 4'd2, 3'b110, 2'b11, 2'b11, 5'b11010},
    {7'd2,  4'd4, 4'd2, 4'd8, 4'd0, 3'b000, 2'b10, 2'b11, 5'b00010},
    {7'd8,  4'd4, 4'd2, 4'd0, 4'd8, 3'b100, 2'b00, 2'b00, 5'b01100},
    {7'd24, 4'd4, 4'd2, 4'd0, 4'd8, 3'b101, 2'b00, 2'b00, 5'b01010},
    {7'd16, 4'd4, 4'd2, 4'd0, 4'd8, 3'b100, 2'b00, 2'b00, 5'b01000},
    {7'd40, 4'd4, 4'd2, 4'd0, 4'd8, 3'b100, 2'b00, 2'b00, 5'b01010},
    {7'd88, 4'd4, 4'd2, 4'd0, 4'd8, 3'b101, 2'b00, 2'b00, 5'b01110},
    {7'd1,  4'd4, 4'd2, 4'd4, 4'd2, 3'b101, 2'b00, 2'b11, 5'b10011},
    {7'd15, 4'd4, 4'd2, 4'd4, 4'd2, 3'b010, 2'b11, 2'b11, 5'b00001},
    {7'd4,  4'd0, 4'd8, 4'd0, 4'd8, 3'b011, 2'b01, 2'b11, 5'b10110}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic writeReg(input logic [1:0] a, input logic [6:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic readReg(input logic [1:0] a, output logic [6:0] d);
    addr = a;
    #1 d = rdData;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [6:0] rd;
    // R1 reset state
    repeat (3) @(negedge clk);
    readReg(2'd0, rd);
    check("R1 ctrl reset", 8'(rd), 8'h00);
    check("R1 irq/dma/handoff/sclk", {4'd0, rxIrq, txIrq, rxDmaReq, txDmaReq}, 8'h00);
    check("R1 pins", {5'd0, pinHandoff, sclkPin, txPin}, 8'h00);
    readReg(2'd1, rd);
    check("R1 rx threshold reset", 8'(rd), 8'd4);
    @(negedge clk);
    rst = 1'b0;

    // Table walk, no transfer active
    for (int i = 0; i < NV; i++) begin
      logic [34:0] v;
      v = VECS[i];
      writeReg(2'd0, v[34:28]);
      writeReg(2'd1, 7'(v[27:24]));
      writeReg(2'd2, 7'(v[23:20]));
      rxLevel = v[19:16]; txLevel = v[15:12];
      {txShiftOut, rxPin, sclkRaw} = v[11:9];
      @(negedge clk);
      @(negedge clk);
      readReg(2'd0, rd);
      check("R11 ctrl readback", 8'(rd), 8'(v[34:28]));
      check("R4 irq", {6'd0, rxIrq, txIrq}, {6'd0, v[8:7]});
      check("R5 dma", {6'd0, rxDmaReq, txDmaReq}, {6'd0, v[6:5]});
      check("R6 data path", {5'd0, rxShiftIn, txPin, pinHandoff}, {5'd0, v[4], v[3], v[0]});
      check("R7 R8 sclk pin", {7'd0, sclkPin}, {7'd0, v[2]});
      check("R9 sample edge", {7'd0, sampleOnRise}, {7'd0, v[1]});
      readReg(2'd3, rd);
      check("R2 R3 status", 8'(rd), {6'd0, v[6:5] == 2'b11 ? 2'b11 : {v[5], v[6]}});
    end
    txShiftOut = 1'b0; rxPin = 1'b0; sclkRaw = 1'b0;

    // R10 pin fields deferred during a transfer
    writeReg(2'd0, 7'd0);
    @(negedge clk);
    xferActive = 1'b1;
    writeReg(2'd0, 7'd8);
    repeat (3) @(negedge clk);
    check("R10 pol held in transfer", {7'd0, sclkPin}, 8'd0);
    readReg(2'd0, rd);
    check("R10 readback immediate", 8'(rd), 8'd8);
    xferActive = 1'b0;
    repeat (2) @(negedge clk);
    check("R10 pol applied when idle", {7'd0, sclkPin}, 8'd1);

    // R10 interrupt enable acts during a transfer
    writeReg(2'd1, 7'd4);
    rxLevel = 4'd6;
    xferActive = 1'b1;
    writeReg(2'd0, 7'd2);
    check("R10 rx enable immediate", {7'd0, rxIrq}, 8'd1);
    xferActive = 1'b0;

    // R4 clearing the enable leaves status alone
    writeReg(2'd0, 7'd0);
    check("R4 irq masked", {7'd0, rxIrq}, 8'd0);
    readReg(2'd3, rd);
    check("R4 status kept", 8'(rd[0]), 8'd1);
    check("R5 dma kept", {7'd0, rxDmaReq}, 8'd1);
    rxLevel = 4'd1;
    @(negedge clk);
    readReg(2'd3, rd);
    check("R4 status still clears", 8'(rd[0]), 8'd0);
    rxLevel = 4'd7;
    @(negedge clk);
    readReg(2'd3, rd);
    check("R4 status still sets", 8'(rd[0]), 8'd1);
    check("R2 level 7 threshold 4", {7'd0, rxDmaReq}, 8'd1);

    // R3 transmit boundary: threshold 0
    writeReg(2'd2, 7'd0);
    txLevel = 4'd1;
    @(negedge clk);
    check("R3 level 1 above threshold 0", {7'd0, txDmaReq}, 8'd0);
    txLevel = 4'd0;
    @(negedge clk);
    check("R3 level 0 at threshold 0", {7'd0, txDmaReq}, 8'd1);

    // R6 frame pin
    frmRaw = 1'b1;
    writeReg(2'd0, 7'd1);
    @(negedge clk);
    check("R6 frame parked in loop", {7'd0, frmPin}, 8'd0);
    writeReg(2'd0, 7'd0);
    @(negedge clk);
    check("R6 frame passes when loop off", {7'd0, frmPin}, 8'd1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule